// File: doc/BRIEF.md
# Frequency Counter Gate Controller

This block measures the frequency of an input signal against a fixed reference clock. The reference clock, 10 MHz at the nominal rate, is divided by a parameter (1600 by default) to make a 6.25 kHz time-base tick. A start command loads a requested number of time-base periods and arms the block. The counting window opens exactly on the next time-base tick. It stays open for that many whole periods and shuts on a later tick. While the window is open, rising edges of the input are counted.

When the window closes, software reads the edge count and the number of elapsed time-base periods. Frequency is edge count times the tick rate divided by the period count. The window length is set only by the divided reference, so the reference alone sets the accuracy. The input is asynchronous. It is resynchronised with two flops before edge detection.

Top module: `freq_gate_ctrl`

## Requirements
- R1: The time base fires once every DIV reference cycles. Counting the posedges after reset release from 1, the tick acts at every edge whose index is a multiple of DIV.
- R2: A start pulse sampled at edge s while the block is idle arms it. `busy` goes high from the following cycle. The window opens at T0, the first tick edge strictly after s.
- R3: A requested period count of 0 or 1 is treated as 2. Larger requests are used as given.
- R4: With an effective count N, the window closes at edge T0 + N*DIV. `done` is high from the cycle after that edge, `busy` drops at the same edge, and `period_count` then reads N.
- R5: A rise of `sig_in`, first seen high at edge k after being low at edge k-1, is counted if and only if T0 < k+2 <= T0 + N*DIV. This reflects two synchroniser flops plus one edge-detect register. Accepting a start clears the count.
- R6: A start pulse while `busy` is high has no effect on the running measurement or its results.
- R7: When the count would pass 2^CW-1 it holds at 2^CW-1 and `overflow` is set. `overflow` stays set until the next accepted start clears it.
- R8: After `done` rises, `done`, `event_count`, `period_count` and `overflow` hold their values until the next accepted start, which clears `done`.
- R9: After reset, `busy`, `done`, `overflow`, `event_count` and `period_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| start | input | 1 | One-cycle measurement request |
| periods_req | input | PW | Requested number of time-base periods |
| busy | output | 1 | Armed or window open |
| done | output | 1 | Result valid |
| event_count | output | CW | Rising edges counted in the window |
| period_count | output | PW | Time-base periods elapsed in the window |
| overflow | output | 1 | Sticky edge-count saturation flag |

## Verification
The main function is tried with several input patterns:
- square waves of random period, which test the count against a steady edge rate;
- random bit streams, which put edges close to the window boundaries and so expose an off-by-one cycle in the window or in the synchroniser latency;
- a silent input, which must give a count of zero;
- a one-cycle toggle over a long window, which drives the counter into saturation.

Directed requests of 0 and 1 separate clamping from plain use of the request. A start issued mid-window shows whether a busy block really ignores it.

// File: rtl/fgc_pkg.sv
// Package: shared state type and the request clamp for the gate controller.
package fgc_pkg;
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_ARM  = 2'd1,
        GS_OPEN = 2'd2
    } gate_state_t;

    localparam int MIN_PERIODS = 2;
endpackage

// File: rtl/fgc_timebase.sv
// Module: fgc_timebase
// Divides the reference clock by DIV and produces a one-cycle tick.
// Assumes DIV >= 2. The counter restarts from zero on reset, so the tick
// acts at every DIV-th edge after reset release.
module fgc_timebase #(
    parameter int DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNTW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);

    logic [CNTW-1:0] cnt;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + CNTW'(1);
    end

    assign tick = (cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
endmodule

// File: rtl/fgc_insync.sv
// Module: fgc_insync
// Brings the asynchronous input into the clock domain with two flops. It
// flags a rising edge for one cycle, one register after the synchroniser.
// Assumes the input is slower than half the clock rate.
module fgc_insync (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // Two-flop synchroniser followed by a delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sig_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/fgc_gate_fsm.sv
// Module: fgc_gate_fsm
// Sequences a measurement: it accepts a start, waits for a time-base tick,
// holds the gate open for the clamped number of periods and closes it on a
// tick. Assumes tick is a single-cycle pulse. A start while busy is dropped.
module fgc_gate_fsm
    import fgc_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] periods_req,
    input  logic          tick,
    output logic          accept,
    output logic          gate,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] period_count
);
    localparam logic [PW-1:0] MINP = PW'(MIN_PERIODS);

    gate_state_t   state;
    logic [PW-1:0] target;
    logic [PW-1:0] pcnt;
    logic [PW-1:0] pcnt_nxt;

    assign accept   = start && (state == GS_IDLE);
    assign pcnt_nxt = pcnt + PW'(1);

    // State, target, elapsed-period and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= GS_IDLE;
            target <= '0;
            pcnt   <= '0;
            done   <= 1'b0;
        end else begin
            case (state)
                GS_IDLE: if (start) begin
                    state  <= GS_ARM;
                    target <= (periods_req < MINP) ? MINP : periods_req;
                    pcnt   <= '0;
                    done   <= 1'b0;
                end
                GS_ARM: if (tick) state <= GS_OPEN;
                GS_OPEN: if (tick) begin
                    pcnt <= pcnt_nxt;
                    if (pcnt_nxt == target) begin
                        state <= GS_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= GS_IDLE;
            endcase
        end
    end

    assign gate         = (state == GS_OPEN);
    assign busy         = (state != GS_IDLE);
    assign period_count = pcnt;

    AST_OPEN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(tick)); // R2
    AST_CLOSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> ($past(tick) && done)); // R4
    AST_MIN_PERIODS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (period_count >= MINP)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(period_count))); // R8
endmodule

// File: rtl/fgc_event_counter.sv
// Module: fgc_event_counter
// Counts rise pulses while the gate is open and saturates at all-ones
// with a sticky overflow flag. A clear (accepted start) resets both.
module fgc_event_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          gate,
    input  logic          rise,
    output logic [CW-1:0] count,
    output logic          ovf
);
    // Gated saturating counter with sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (gate && rise) begin
            if (&count) ovf <= 1'b1;
            else        count <= count + CW'(1);
        end
    end

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !clr) |=> $stable(count)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> (ovf && (&count))); // R7
endmodule

// File: rtl/freq_gate_ctrl.sv
// Module: freq_gate_ctrl (top)
// Frequency counter gate controller. The time base is the reference clock
// divided by DIV. The counting window spans a whole number of time-base
// periods and opens and closes on ticks. Assumes clk is the reference clock
// and sig_in is asynchronous.
module freq_gate_ctrl #(
    parameter int DIV = 1600,
    parameter int PW  = 16,
    parameter int CW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_in,
    input  logic          start,
    input  logic [PW-1:0] periods_req,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] event_count,
    output logic [PW-1:0] period_count,
    output logic          overflow
);
    logic tick, rise, accept, gate;

    fgc_timebase #(.DIV(DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    fgc_insync u_sync (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rise(rise)
    );

    fgc_gate_fsm #(.PW(PW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .periods_req(periods_req),
        .tick(tick), .accept(accept), .gate(gate), .busy(busy),
        .done(done), .period_count(period_count)
    );

    fgc_event_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(accept), .gate(gate), .rise(rise),
        .count(event_count), .ovf(overflow)
    );

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
endmodule

// File: tb/tb_freq_gate_ctrl.sv
// Bench for freq_gate_ctrl: random and directed measurements are checked
// against a cycle model built from the requirements.
module tb_freq_gate_ctrl;
    localparam int DIV = 20;
    localparam int PW  = 8;
    localparam int CW  = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] periods_req = '0;
    logic          busy, done, overflow;
    logic [CW-1:0] event_count;
    logic [PW-1:0] period_count;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    freq_gate_ctrl #(.DIV(DIV), .PW(PW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
        .periods_req(periods_req), .busy(busy), .done(done),
        .event_count(event_count), .period_count(period_count),
        .overflow(overflow)
    );

    always #5 clk = ~clk;

    // Stimulus pattern: 0 square, 1 random bits, 2 silent, 3 toggle each cycle
    int mode = 2;
    int half = 3;
    int phase = 0;
    always @(negedge clk) begin
        case (mode)
            0: begin
                phase = phase + 1;
                if (phase >= half) begin phase = 0; sig_in <= ~sig_in; end
            end
            1: sig_in <= 1'($urandom_range(0, 1));
            3: sig_in <= ~sig_in;
            default: sig_in <= 1'b0;
        endcase
    end

    // Cycle model: edge index, window bounds and expected edge count
    int e = 0;
    int t0 = 0;
    int tn = 0;
    int exp_cnt = 0;
    logic sig_q = 1'b0;
    logic [1:0] rhist = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            e = 0; sig_q = 1'b0; rhist = '0;
        end else begin
            e = e + 1;
            if (rhist[1] && e > t0 && e <= tn) exp_cnt = exp_cnt + 1;
            rhist = {rhist[0], (sig_in && !sig_q)};
            sig_q = sig_in;
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int eff_periods(input int req);
        return (req < 2) ? 2 : req;
    endfunction

    function automatic int sat_count(input int c);
        return (c > CMAX) ? CMAX : c;
    endfunction

    // One measurement; optionally pulses start mid-window with another request
    task automatic measure(input int req, input bit poke);
        int s;
        int n;
        int hold;
        n = eff_periods(req);
        @(negedge clk);
        start = 1'b1;
        periods_req = PW'(req);
        s  = e + 1;
        t0 = ((s / DIV) + 1) * DIV;
        tn = t0 + n * DIV;
        exp_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after start", busy, 1);
        chk("R8", "done cleared by start", done, 0);
        if (poke) begin
            while (e < t0 + 3) @(negedge clk);
            start = 1'b1;
            periods_req = PW'(n + 5);
            @(negedge clk);
            start = 1'b0;
            chk("R6", "busy after ignored start", busy, 1);
        end
        while (e < tn - 1) @(negedge clk);
        chk("R4", "done before close edge", done, 0);
        @(negedge clk);
        chk("R4", "done after close edge", done, 1);
        chk("R4", "busy after close edge", busy, 0);
        chk(req < 2 ? "R3" : "R4", "period_count", period_count, n);
        chk("R5", "event_count", event_count, sat_count(exp_cnt));
        chk("R7", "overflow", overflow, (exp_cnt > CMAX) ? 1 : 0);
        hold = $urandom_range(1, 15);
        repeat (hold) @(negedge clk);
        chk("R8", "done held", done, 1);
        chk("R8", "event_count held", event_count, sat_count(exp_cnt));
        chk("R8", "period_count held", period_count, n);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R9", "busy in reset", busy, 0);
        chk("R9", "done in reset", done, 0);
        chk("R9", "overflow in reset", overflow, 0);
        chk("R9", "event_count in reset", event_count, 0);
        chk("R9", "period_count in reset", period_count, 0);
        rst_n = 1'b1;
        // R1: immediate start, first window opens at edge DIV
        mode = 0; half = 2;
        measure(3, 1'b0);
        // R3: clamped requests
        mode = 1;
        measure(0, 1'b0);
        measure(1, 1'b0);
        // R6: start while busy
        mode = 0; half = 3;
        measure(4, 1'b1);
        // R5: silent input
        mode = 2;
        measure(3, 1'b0);
        chk("R5", "silent count", event_count, 0);
        // R7: saturation, then cleared by the next start
        mode = 3;
        measure(30, 1'b0);
        chk("R7", "overflow set", overflow, 1);
        mode = 2;
        measure(2, 1'b0);
        chk("R7", "overflow cleared", overflow, 0);
        // Random measurements
        for (int i = 0; i < 14; i++) begin
            mode = ($urandom_range(0, 3) == 0) ? 1 : 0;
            half = $urandom_range(1, 6);
            repeat ($urandom_range(0, 25)) @(negedge clk);
            measure($urandom_range(0, 6), 1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule